// File: doc/BRIEF.md
# Frequency and Period Measurement Counter

This block measures either the frequency or the period of an external signal for a tuner controller. It has two signal inputs: a high-frequency input that is halved before counting, and a low-frequency input that is counted directly. In frequency mode it counts rising edges during a gate whose length is set by a 2-bit code. In period mode it counts cycles of a reference tick over one or two periods of the low-frequency input. A settling wait comes before every measurement. A completion flag reports the end of each measurement, and the 20-bit result can accumulate across restarts.

All timing comes from a one-pulse-per-millisecond tick enable, so the whole block runs on one clock. A control word is applied with a one-cycle load strobe. A word with the enable bit clear stops the block and zeroes the result. A word with the enable bit set starts a measurement and keeps the result held so far. To integrate, the controller sends enable-set words again and again. To start a fresh measurement from zero, it sends an enable-clear word first.

The control unit is a state machine with six states:
- IDLE: held in reset.
- SETTLE: the input-settling wait.
- GATE: frequency counting.
- ARM: period mode, waiting for the first low-input edge.
- SPAN: period mode, counting reference ticks.
- DONE: the result is held.

Its transitions are:
- Any state goes to IDLE on a load with enable 0.
- Any state goes to SETTLE on a load with enable 1.
- SETTLE goes to GATE when the wait expires in frequency mode, or to ARM in period mode.
- GATE goes to DONE when the gate expires.
- ARM goes to SPAN on a low-input rising edge.
- SPAN goes to DONE on the closing low-input edge. In two-period mode, the first low-input edge in SPAN stays in SPAN.

Top module: `meas_counter`

## Requirements
- R1: After reset, `result` is 0 and `done` is 0.
- R2: A load with `cfg_enable`=0 makes `result` 0 and `done` 0 from the next cycle. No later millisecond ticks or edges change either output until a load with `cfg_enable`=1.
- R3: With `cfg_src`=1x (high input, frequency mode), the divide-by-two stage is cleared on load and advances only during the gate. The result grows by floor(E/2), where E is the number of `hf_in` rising edges in the gate.
- R4: With `cfg_src`=01 (low input, frequency mode), the result grows by one for each `lf_in` rising edge during the gate.
- R5: The gate lasts 4, 8, 32 or 64 millisecond ticks for `cfg_gate` codes 00, 01, 10 and 11. `done` rises the cycle after the last of these ticks.
- R6: The settling wait lasts 2 ticks when `cfg_fast_bias`=1. When `cfg_fast_bias`=0 it lasts 4 ticks for gate codes 0x and 8 ticks for codes 1x. Input edges during the wait are not counted.
- R7: With `cfg_src`=00 (period mode), after the wait the first `lf_in` rising edge opens the span. Each `ref_tick` then adds one, until 1 further rising edge (gate code 0x) or 2 further rising edges (gate code 1x) close it. Reference ticks before the opening edge are not counted.
- R8: `done` is set when the gate or span closes. It is cleared on the cycle after any load. While `done` is 1, `result` does not change.
- R9: A load with `cfg_enable`=1 restarts the measurement without clearing `result`, and the new count is added to the held value.
- R10: The result wraps modulo 2^CNT_W with no error indication. CNT_W defaults to 20, giving a range of 0x00000 to 0xFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| ref_tick | input | 1 | Reference tick (nominal 900 kHz) used in period mode |
| hf_in | input | 1 | High-frequency measured signal, synchronous to clk |
| lf_in | input | 1 | Low-frequency measured signal, synchronous to clk |
| cfg_load | input | 1 | One-cycle strobe that applies the control fields |
| cfg_enable | input | 1 | 1 starts or restarts a measurement, 0 holds the block in reset |
| cfg_src | input | 2 | Mode select: 1x high-input frequency, 01 low-input frequency, 00 low-input period |
| cfg_gate | input | 2 | Gate length (frequency mode) or span of one or two periods (period mode) |
| cfg_fast_bias | input | 1 | 1 selects the short settling wait |
| result | output | CNT_W | Measurement count |
| done | output | 1 | Measurement complete |

## Verification
The hardest situation to reach is a result wrap. At the default width it takes more than a million counted events, which is far too long for a directed run. The bench therefore drives a second instance with an 8-bit result from the same stimulus. It integrates two period-mode spans of 200 and 100 reference ticks, so the narrow instance must show 44 while the default instance shows 300. Gate and wait boundaries are reached by issuing millisecond ticks one at a time from the bench and checking `done` one tick before and at the expected close.

// File: rtl/meas_pkg.sv
package meas_pkg;

    localparam int MS_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_GATE   = 3'd2,
        ST_ARM    = 3'd3,
        ST_SPAN   = 3'd4,
        ST_DONE   = 3'd5
    } meas_state_t;

    // gate length in millisecond ticks per 2-bit code
    function automatic logic [MS_W-1:0] gate_len(input logic [1:0] code);
        logic [MS_W-1:0] len;
        unique case (code)
            2'b00:   len = 7'd4;
            2'b01:   len = 7'd8;
            2'b10:   len = 7'd32;
            default: len = 7'd64;
        endcase
        return len;
    endfunction

    // settling wait in millisecond ticks
    function automatic logic [MS_W-1:0] settle_len(input logic [1:0] code,
                                                   input logic       fast);
        logic [MS_W-1:0] len;
        if (fast)
            len = 7'd2;
        else if (code[1])
            len = 7'd8;
        else
            len = 7'd4;
        return len;
    endfunction

endpackage

// File: rtl/meas_edge.sv
module meas_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_in,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= '0;
        else
            prev_q <= sig_in;
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        assign rise[i] = sig_in[i] & ~prev_q[i];
    end
endmodule

// File: rtl/meas_halver.sv
module meas_halver (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic pulse
);
    logic phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= 1'b0;
        else if (clr)
            phase_q <= 1'b0;
        else if (adv)
            phase_q <= ~phase_q;
    end

    assign pulse = adv & phase_q;
endmodule

// File: rtl/meas_mswin.sv
module meas_mswin #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_q;

    assign hit = tick && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr || hit)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/meas_accum.sv
module meas_accum #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            value <= '0;
        else if (clr)
            value <= '0;
        else if (inc)
            value <= value + 1'b1;
    end
endmodule

// File: rtl/meas_counter.sv
module meas_counter
    import meas_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             ref_tick,
    input  logic             hf_in,
    input  logic             lf_in,
    input  logic             cfg_load,
    input  logic             cfg_enable,
    input  logic [1:0]       cfg_src,
    input  logic [1:0]       cfg_gate,
    input  logic             cfg_fast_bias,
    output logic [CNT_W-1:0] result,
    output logic             done
);
    meas_state_t state_q, state_d;
    logic [1:0]  src_q, gate_q;
    logic        fast_q;
    logic        two_left_q;
    logic [1:0]  rise_v;
    logic        hf_rise, lf_rise, hf_half;
    logic        win_hit, win_run;
    logic [MS_W-1:0] win_limit;
    logic        inc;
    logic        period_mode;

    assign hf_rise     = rise_v[0];
    assign lf_rise     = rise_v[1];
    assign period_mode = (src_q == 2'b00);

    meas_edge #(.N(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in ({lf_in, hf_in}),
        .rise   (rise_v)
    );

    meas_halver u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_load),
        .adv   (hf_rise && state_q == ST_GATE && !cfg_load),
        .pulse (hf_half)
    );

    assign win_run   = (state_q == ST_SETTLE) || (state_q == ST_GATE);
    assign win_limit = (state_q == ST_SETTLE) ? settle_len(gate_q, fast_q)
                                              : gate_len(gate_q);

    meas_mswin #(.W(MS_W)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_load),
        .tick  (ms_tick && win_run && !cfg_load),
        .limit (win_limit),
        .hit   (win_hit)
    );

    meas_accum #(.W(CNT_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_load && !cfg_enable),
        .inc   (inc),
        .value (result)
    );

    // control fields captured on load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q      <= 2'b00;
            gate_q     <= 2'b00;
            fast_q     <= 1'b0;
            two_left_q <= 1'b0;
        end else if (cfg_load) begin
            src_q      <= cfg_src;
            gate_q     <= cfg_gate;
            fast_q     <= cfg_fast_bias;
            two_left_q <= cfg_gate[1];
        end else if (state_q == ST_SPAN && lf_rise) begin
            two_left_q <= 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (cfg_load) begin
            state_d = cfg_enable ? ST_SETTLE : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_SETTLE: if (win_hit) state_d = period_mode ? ST_ARM : ST_GATE;
                ST_GATE:   if (win_hit) state_d = ST_DONE;
                ST_ARM:    if (lf_rise) state_d = ST_SPAN;
                ST_SPAN:   if (lf_rise) state_d = two_left_q ? ST_SPAN : ST_DONE;
                ST_DONE:   state_d = ST_DONE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        done = (state_q == ST_DONE);
        inc  = 1'b0;
        if (!cfg_load) begin
            unique case (state_q)
                ST_GATE: inc = src_q[1] ? hf_half : lf_rise;
                ST_SPAN: inc = ref_tick;
                default: inc = 1'b0;
            endcase
        end
    end

    AST_LOAD_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> !done); // R8

    AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_load) |=> $stable(result)); // R8

    AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && !cfg_load) |=> $stable(result)); // R6

    AST_ARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM && !cfg_load) |=> $stable(result)); // R7

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (result == '0 && !done)); // R2
endmodule

// File: tb/sim_meas_counter.sv
`timescale 1ns/1ps
module sim_meas_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b0, ref_tick = 1'b0, hf_in = 1'b0, lf_in = 1'b0;
    logic        cfg_load = 1'b0, cfg_enable = 1'b0, cfg_fast_bias = 1'b0;
    logic [1:0]  cfg_src = 2'b00, cfg_gate = 2'b00;
    logic [19:0] result;
    logic [7:0]  result8;
    logic        done, done8;
    int          n_chk = 0, n_bad = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    meas_counter u0 (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ref_tick(ref_tick),
        .hf_in(hf_in), .lf_in(lf_in), .cfg_load(cfg_load), .cfg_enable(cfg_enable),
        .cfg_src(cfg_src), .cfg_gate(cfg_gate), .cfg_fast_bias(cfg_fast_bias),
        .result(result), .done(done));

    meas_counter #(.CNT_W(8)) u1 (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ref_tick(ref_tick),
        .hf_in(hf_in), .lf_in(lf_in), .cfg_load(cfg_load), .cfg_enable(cfg_enable),
        .cfg_src(cfg_src), .cfg_gate(cfg_gate), .cfg_fast_bias(cfg_fast_bias),
        .result(result8), .done(done8));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1; step; ms_tick = 1'b0; step;
        end
    endtask

    task automatic lf_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            lf_in = 1'b1; step; lf_in = 1'b0; step;
        end
    endtask

    task automatic hf_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            hf_in = 1'b1; step; hf_in = 1'b0; step;
        end
    endtask

    task automatic refs(input int n);
        for (int i = 0; i < n; i++) begin
            ref_tick = 1'b1; step; ref_tick = 1'b0; step;
        end
    endtask

    task automatic load(input logic en, input logic [1:0] src,
                        input logic [1:0] gate, input logic fast);
        cfg_enable = en; cfg_src = src; cfg_gate = gate; cfg_fast_bias = fast;
        cfg_load = 1'b1; step; cfg_load = 1'b0; step;
    endtask

    task automatic t_reset;
        chk("R1 result after reset", result, 0);
        chk("R1 done after reset", done, 0);
    endtask

    task automatic t_lf_freq;
        load(1, 2'b01, 2'b01, 1);
        ticks(2);
        lf_pulses(6);
        ticks(7);
        chk("R5 gate 01 open at 7 ticks", done, 0);
        ticks(1);
        chk("R8 done at gate close", done, 1);
        chk("R4 low-input edge count", result, 6);
        lf_pulses(2);
        chk("R8 result frozen while done", result, 6);
    endtask

    task automatic t_hf_freq;
        load(0, 2'b00, 2'b00, 0);
        load(1, 2'b10, 2'b00, 1);
        hf_pulses(1);
        ticks(2);
        hf_pulses(7);
        ticks(4);
        chk("R3 high input halved", result, 3);
        chk("R3 done", done, 1);
    endtask

    task automatic t_settle;
        load(0, 2'b00, 2'b00, 0);
        load(1, 2'b01, 2'b10, 0);
        ticks(7);
        lf_pulses(3);
        chk("R6 edges in wait ignored", result, 0);
        ticks(1);
        lf_pulses(2);
        ticks(31);
        chk("R5 gate 10 open at 31 ticks", done, 0);
        ticks(1);
        chk("R5 gate 10 closed at 32 ticks", done, 1);
        chk("R6 count after 8-tick wait", result, 2);
    endtask

    task automatic t_period_one;
        load(0, 2'b00, 2'b00, 0);
        load(1, 2'b00, 2'b00, 1);
        ticks(2);
        refs(4);
        chk("R7 refs before opening edge ignored", result, 0);
        lf_pulses(1);
        refs(9);
        chk("R7 span still open", done, 0);
        lf_pulses(1);
        chk("R7 one-period done", done, 1);
        chk("R7 one-period count", result, 9);
    endtask

    task automatic t_period_two;
        load(0, 2'b00, 2'b00, 0);
        load(1, 2'b00, 2'b10, 1);
        ticks(2);
        lf_pulses(1);
        refs(5);
        lf_pulses(1);
        chk("R7 two-period still open after one", done, 0);
        chk("R7 partial count", result, 5);
        refs(6);
        lf_pulses(1);
        chk("R7 two-period done", done, 1);
        chk("R7 two-period count", result, 11);
    endtask

    task automatic t_integrate;
        load(0, 2'b00, 2'b00, 0);
        load(1, 2'b01, 2'b00, 1);
        ticks(2);
        lf_pulses(5);
        ticks(4);
        chk("R9 first pass", result, 5);
        load(1, 2'b01, 2'b00, 1);
        chk("R8 done cleared on restart", done, 0);
        chk("R9 value kept on restart", result, 5);
        ticks(2);
        lf_pulses(3);
        ticks(4);
        chk("R9 accumulated", result, 8);
        chk("R9 done after second pass", done, 1);
    endtask

    task automatic t_abort;
        load(1, 2'b01, 2'b00, 1);
        ticks(2);
        lf_pulses(2);
        load(0, 2'b01, 2'b00, 1);
        chk("R2 result cleared", result, 0);
        chk("R2 done cleared", done, 0);
        ticks(6);
        lf_pulses(2);
        chk("R2 no completion while disabled", done, 0);
        chk("R2 no count while disabled", result, 0);
    endtask

    task automatic t_wrap;
        load(0, 2'b00, 2'b00, 0);
        load(1, 2'b00, 2'b00, 1);
        ticks(2);
        lf_pulses(1);
        refs(200);
        lf_pulses(1);
        chk("R10 narrow first span", result8, 200);
        load(1, 2'b00, 2'b00, 1);
        ticks(2);
        lf_pulses(1);
        refs(100);
        lf_pulses(1);
        chk("R10 wide no wrap", result, 300);
        chk("R10 narrow wrapped", result8, 44);
        chk("R10 narrow done", done8, 1);
    endtask

    initial begin
        step; step;
        rst_n = 1'b1;
        step;
        t_reset;
        t_lf_freq;
        t_hf_freq;
        t_settle;
        t_period_one;
        t_period_two;
        t_integrate;
        t_abort;
        t_wrap;
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule